// File: doc/BRIEF.md
# Battery Switchover and Power-Event Interrupt Unit

This block chooses whether the switched supply rail is fed from the main supply or from the backup battery. It takes single-bit comparator results as inputs: main supply low, auxiliary DC input low, main supply good, and battery low. It also takes a one-cycle pulse that marks a finished battery measurement. The block drives a select output toward the supply switches.

A 2-bit mode field chooses which faults move the rail onto the battery. The fault, and its removal, must hold for a programmable number of clock cycles before the select moves, so a chattering comparator cannot toggle the rail.

Power events are logged in sticky flag bits. Each flag has an enable bit at the same position, and together they drive a single registered interrupt. A small register port gives access to the flags, the enables, the mode field and the status bits. Read data is registered, so it appears one clock after the address is presented.

Top module: `pwr_switch_irq`

## Requirements
- R1: After reset, the flags, the enables and the mode field read 0. The select output is 1 (main supply), the interrupt is 0, and the status register reads 0x03.
- R2: In mode 00, a low main supply moves the select to 0 (battery). A low auxiliary input alone does not move it.
- R3: In mode 01, either a low main supply or a low auxiliary input moves the select to battery. The select returns to 1 only when both faults have cleared.
- R4: When mode bit 1 is set, no fault moves the select. The select is forced to 1 within two clocks, even if it was on battery.
- R5: A change of the fault condition reaches the select exactly 2+DEBOUNCE_CYC clocks after the input changes (2 synchronizer stages plus the stability count). A condition that lasts fewer than DEBOUNCE_CYC synchronized cycles leaves the select unchanged.
- R6: Flag bit 1 is set when the select goes from main to battery. Flag bit 3 is set when the select goes from battery back to main.
- R7: Flag bit 0 is set on the rising edge of the auxiliary-low input. Flag bit 2 is set on the rising edge of battery-low, or on a battery-measurement-ready pulse.
- R8: Writing 0 to a flag bit at address 0 clears that bit, and writing 1 leaves it unchanged. A hardware set in the same clock as a clear wins.
- R9: The interrupt output is 1 exactly when some flag bit and the enable bit at the same position are both 1. It is registered one clock behind the registers.
- R10: The register map is: address 0 holds flags [3:0], address 1 holds enables [3:0], address 2 holds the mode in [1:0], and address 3 holds status (bit 0 = select, bit 1 = main ready). Reserved bits read 0 and ignore writes. The status register ignores writes.
- R11: The main-ready status bit follows the main-supply-good input through the 2-flop synchronizer, and it resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_low_i | input | 1 | Main supply below threshold (asynchronous) |
| aux_low_i | input | 1 | Auxiliary DC input below threshold (asynchronous) |
| main_good_i | input | 1 | Main supply ready (asynchronous) |
| bat_low_i | input | 1 | Battery below programmed threshold (asynchronous) |
| bat_rdy_i | input | 1 | One-cycle battery-measurement-ready pulse (synchronous) |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Registered read data |
| sel_main_o | output | 1 | 1 = rail on main supply, 0 = rail on battery |
| irq_o | output | 1 | Power-management interrupt |

## Verification
Each mode is driven with every combination of main-low and auxiliary-low, directed and randomly with a fixed seed, after the inputs settle. This separates mode 00, which ignores the auxiliary input, from mode 01, which ORs the two faults, and from the disabled modes, which force the main supply. Fault pulses just below the stability count and a change timed edge by edge show whether the debounce count is exact and free of an off-by-one. A flag clear written in the same clock as a measurement-ready pulse shows whether the hardware set wins the race.

// File: rtl/pswi_pkg.sv
package pswi_pkg;
  // Event flags, LSB first: aux low, to battery, battery event, restored
  typedef struct packed {
    logic restore;
    logic bat;
    logic to_bat;
    logic aux;
  } evt_t;

  localparam int NFLAG = $bits(evt_t);

  localparam logic [1:0] ADDR_FLAG = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam logic [1:0] MODE_MAIN     = 2'b00;
  localparam logic [1:0] MODE_MAIN_AUX = 2'b01;
endpackage

// File: rtl/psw_sync.sv
module psw_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[0] <= RST_VAL;
          else     st[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[s] <= RST_VAL;
          else     st[s] <= st[s-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/psw_switch.sv
module psw_switch
  import pswi_pkg::*;
#(
  parameter int DEB_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       main_low,
  input  logic       aux_low,
  output logic       sel_main,
  output logic       to_bat_p,
  output logic       to_main_p
);
  localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYC - 1);

  logic          fault;
  logic          want_main;
  logic [CW-1:0] cnt;

  always_comb begin
    if (mode == MODE_MAIN_AUX) fault = main_low | aux_low;
    else                       fault = main_low;
    want_main = ~fault;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_main  <= 1'b1;
      cnt       <= '0;
      to_bat_p  <= 1'b0;
      to_main_p <= 1'b0;
    end else begin
      to_bat_p  <= 1'b0;
      to_main_p <= 1'b0;
      if (mode[1]) begin
        cnt <= '0;
        if (!sel_main) begin
          sel_main  <= 1'b1;
          to_main_p <= 1'b1;
        end
      end else if (want_main == sel_main) begin
        cnt <= '0;
      end else if (cnt == CNT_LAST) begin
        cnt       <= '0;
        sel_main  <= want_main;
        to_main_p <= want_main;
        to_bat_p  <= ~want_main;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R4
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    mode[1] |=> sel_main);

  // R2 R3
  to_bat_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_main) |-> $past(fault));

  // R6
  to_bat_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    to_bat_p |-> !sel_main);

  // R6
  to_main_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    to_main_p |-> sel_main);
endmodule

// File: rtl/psw_regs.sv
module psw_regs
  import pswi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  input  evt_t          evt_set,
  input  logic          sel_main,
  input  logic          main_ready,
  output logic [DW-1:0] reg_rdata,
  output logic [1:0]    mode,
  output logic          irq
);
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] en_q;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic             wr_flag;
  logic             unused_wdata;

  assign set_v        = evt_set;
  assign wr_flag      = reg_wr && (reg_addr == ADDR_FLAG);
  assign clr_v        = wr_flag ? ~reg_wdata[NFLAG-1:0] : '0;
  assign unused_wdata = ^reg_wdata[DW-1:NFLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= '0;
      en_q      <= '0;
      mode      <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_v) | set_v;
      if (reg_wr && reg_addr == ADDR_EN)  en_q <= reg_wdata[NFLAG-1:0];
      if (reg_wr && reg_addr == ADDR_CFG) mode <= reg_wdata[1:0];
      irq <= |(flag_q & en_q);
      case (reg_addr)
        ADDR_FLAG: reg_rdata <= {{(DW-NFLAG){1'b0}}, flag_q};
        ADDR_EN:   reg_rdata <= {{(DW-NFLAG){1'b0}}, en_q};
        ADDR_CFG:  reg_rdata <= {{(DW-2){1'b0}}, mode};
        default:   reg_rdata <= {{(DW-2){1'b0}}, main_ready, sel_main};
      endcase
    end
  end

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag_chk
      // R8
      flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q[i]) |-> $past(wr_flag && !reg_wdata[i]));
      // R8
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_v[i] |=> flag_q[i]);
    end
  endgenerate

  // R9
  irq_on_chk: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & en_q)) |=> irq);

  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & en_q)) |=> !irq);
endmodule

// File: rtl/pwr_switch_irq.sv
module pwr_switch_irq
  import pswi_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEBOUNCE_CYC = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          main_low_i,
  input  logic          aux_low_i,
  input  logic          main_good_i,
  input  logic          bat_low_i,
  input  logic          bat_rdy_i,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          sel_main_o,
  output logic          irq_o
);
  // synchronized bits: {main_good, bat_low, aux_low, main_low}
  localparam logic [3:0] SYNC_RST = 4'b1000;

  logic [3:0] sync_q;
  logic       main_low_s, aux_low_s, bat_low_s, main_good_s;
  logic       aux_low_d, bat_low_d;
  logic [1:0] mode;
  logic       to_bat_p, to_main_p;
  evt_t       evt;

  psw_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({main_good_i, bat_low_i, aux_low_i, main_low_i}),
    .q   (sync_q)
  );

  assign {main_good_s, bat_low_s, aux_low_s, main_low_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_low_d <= 1'b0;
      bat_low_d <= 1'b0;
    end else begin
      aux_low_d <= aux_low_s;
      bat_low_d <= bat_low_s;
    end
  end

  psw_switch #(.DEB_CYC(DEBOUNCE_CYC)) u_switch (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .main_low  (main_low_s),
    .aux_low   (aux_low_s),
    .sel_main  (sel_main_o),
    .to_bat_p  (to_bat_p),
    .to_main_p (to_main_p)
  );

  always_comb begin
    evt.aux     = aux_low_s & ~aux_low_d;
    evt.bat     = (bat_low_s & ~bat_low_d) | bat_rdy_i;
    evt.to_bat  = to_bat_p;
    evt.restore = to_main_p;
  end

  psw_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr_i),
    .reg_wr     (reg_wr_i),
    .reg_wdata  (reg_wdata_i),
    .evt_set    (evt),
    .sel_main   (sel_main_o),
    .main_ready (main_good_s),
    .reg_rdata  (reg_rdata_o),
    .mode       (mode),
    .irq        (irq_o)
  );
endmodule

// File: tb/pwr_switch_irq_test.sv
`timescale 1ns/1ps
module pwr_switch_irq_test;
  localparam int DW = 8;
  localparam int DEB = 4;
  localparam int SEED = 1234;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          main_low_i = 1'b0, aux_low_i = 1'b0, main_good_i = 1'b1;
  logic          bat_low_i = 1'b0, bat_rdy_i = 1'b0;
  logic [1:0]    reg_addr_i = 2'd0;
  logic          reg_wr_i = 1'b0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [DW-1:0] reg_rdata_o;
  logic          sel_main_o, irq_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pwr_switch_irq #(.DW(DW), .DEBOUNCE_CYC(DEB)) uut (
    .clk(clk), .rst(rst), .main_low_i(main_low_i), .aux_low_i(aux_low_i),
    .main_good_i(main_good_i), .bat_low_i(bat_low_i), .bat_rdy_i(bat_rdy_i),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .sel_main_o(sel_main_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr_i = a;
    @(negedge clk);
    d = reg_rdata_o;
  endtask

  function automatic logic exp_sel(input logic [1:0] m, input logic ml, input logic al);
    if (m[1]) return 1'b1;
    if (m == 2'b01) return !(ml | al);
    return !ml;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic prev_sel;
    logic [1:0] m;
    logic ml, al, es;
    int fexp;
    void'($urandom(SEED));

    cyc(3);
    rst = 1'b0;
    // R1 reset state
    rd(2'd0, d); chk("R1 flags", d, 0);
    rd(2'd1, d); chk("R1 enables", d, 0);
    rd(2'd2, d); chk("R1 mode", d, 0);
    rd(2'd3, d); chk("R1 status", d, 3);
    chk("R1 select", sel_main_o, 1);
    chk("R1 irq", irq_o, 0);

    // R5 exact timing, R2 mode 00 main low
    @(negedge clk); main_low_i = 1'b1;
    cyc(2 + DEB - 1); chk("R5 select before count", sel_main_o, 1);
    cyc(1);           chk("R2 R5 select to battery", sel_main_o, 0);
    cyc(2);
    rd(2'd0, d); chk("R6 to-battery flag", d, 8'h02);
    chk("R9 irq off with no enables", irq_o, 0);
    wr(2'd1, 8'h0D); cyc(2);
    chk("R9 irq off with other enables", irq_o, 0);
    wr(2'd1, 8'h02); cyc(2);
    chk("R9 irq on with matching enable", irq_o, 1);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R8 write 1 keeps flag", d, 8'h02);
    wr(2'd0, 8'h00); cyc(2);
    rd(2'd0, d); chk("R8 write 0 clears flag", d, 8'h00);
    chk("R9 irq drops after clear", irq_o, 0);

    // R6 restore
    @(negedge clk); main_low_i = 1'b0;
    cyc(DEB + 4);
    chk("R6 select back to main", sel_main_o, 1);
    rd(2'd0, d); chk("R6 restored flag", d, 8'h08);
    wr(2'd0, 8'h00);

    // R5 short glitch ignored
    @(negedge clk); main_low_i = 1'b1;
    cyc(DEB - 1); main_low_i = 1'b0;
    cyc(DEB + 6);
    chk("R5 short fault ignored", sel_main_o, 1);
    rd(2'd0, d); chk("R5 no flags from glitch", d, 8'h00);

    // R2 aux low alone in mode 00; R7 aux flag
    @(negedge clk); aux_low_i = 1'b1;
    cyc(DEB + 6);
    chk("R2 aux ignored in mode 00", sel_main_o, 1);
    rd(2'd0, d); chk("R7 aux flag", d, 8'h01);
    wr(2'd0, 8'h00);

    // R3 mode 01
    wr(2'd2, 8'h01);
    cyc(DEB + 6);
    chk("R3 aux low moves to battery", sel_main_o, 0);
    @(negedge clk); main_low_i = 1'b1; aux_low_i = 1'b0;
    cyc(DEB + 6);
    chk("R3 main still low keeps battery", sel_main_o, 0);
    @(negedge clk); main_low_i = 1'b0;
    cyc(DEB + 6);
    chk("R3 both clear returns main", sel_main_o, 1);

    // R4 disabled modes
    wr(2'd2, 8'h02);
    @(negedge clk); main_low_i = 1'b1;
    cyc(DEB + 6);
    chk("R4 disabled ignores fault", sel_main_o, 1);
    wr(2'd2, 8'h00);
    cyc(DEB + 6);
    chk("R2 mode 00 switches", sel_main_o, 0);
    wr(2'd2, 8'h03);
    cyc(1);
    chk("R4 forced back to main", sel_main_o, 1);
    @(negedge clk); main_low_i = 1'b0;
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);

    // R10 reserved bits and read-only status
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk("R10 enable reserved bits", d, 8'h0F);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFC);
    rd(2'd2, d); chk("R10 mode reserved bits", d, 8'h00);
    wr(2'd3, 8'h00);
    rd(2'd3, d); chk("R10 status ignores write", d, 8'h03);

    // R11 main ready
    @(negedge clk); main_good_i = 1'b0;
    cyc(3);
    rd(2'd3, d); chk("R11 main ready low", d, 8'h01);
    @(negedge clk); main_good_i = 1'b1;
    cyc(3);
    rd(2'd3, d); chk("R11 main ready high", d, 8'h03);

    // R7 battery low edge and ready pulse
    @(negedge clk); bat_low_i = 1'b1;
    cyc(4);
    rd(2'd0, d); chk("R7 battery low flag", d, 8'h04);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R7 level alone does not re-set", d, 8'h00);
    @(negedge clk); bat_low_i = 1'b0;
    @(negedge clk); bat_rdy_i = 1'b1;
    @(negedge clk); bat_rdy_i = 1'b0;
    rd(2'd0, d); chk("R7 ready pulse flag", d, 8'h04);
    // R8 set wins over clear in same clock
    @(negedge clk);
    reg_addr_i = 2'd0; reg_wdata_i = 8'h00; reg_wr_i = 1'b1; bat_rdy_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0; bat_rdy_i = 1'b0;
    rd(2'd0, d); chk("R8 set beats clear", d, 8'h04);
    wr(2'd0, 8'h00);

    // Random settled patterns
    prev_sel = sel_main_o;
    for (int it = 0; it < 40; it++) begin
      m  = 2'($urandom() % 4);
      ml = 1'($urandom() % 2);
      al = 1'($urandom() % 2);
      wr(2'd2, {6'd0, m});
      @(negedge clk); main_low_i = ml; aux_low_i = al;
      cyc(DEB + 8);
      es = exp_sel(m, ml, al);
      chk(m == 2'b00 ? "R2 random select" : (m == 2'b01 ? "R3 random select" : "R4 random select"),
          sel_main_o, es);
      fexp = 0;
      if (prev_sel && !es) fexp = 2;
      if (!prev_sel && es) fexp = 8;
      rd(2'd0, d); chk("R6 random switch flags", d & 8'h0A, fexp);
      wr(2'd0, 8'h00);
      prev_sel = es;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule